// File: doc/BRIEF.md
# Single-Accumulator Execution Core

This block is a small sequential processor built around one accumulator register. A short program sits in an internal instruction memory, and the core runs it against an internal word-addressed data memory. Each 16-bit instruction names exactly one data-memory word. The accumulator is always the other operand and always receives the result. Instructions run in strict program order with no branches. Each instruction passes through three phases: instruction fetch, decode with operand read, and write-back with a step of the program counter.

A test harness fills both memories through a preload port, normally while reset is held. It then releases reset and watches the halt flag, the program counter, the accumulator and the data-memory write strobe. The preload port also stays live while the core runs. When a preload write meets a core store in the same cycle, the store has priority.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pc` reads 0, `acc_o` reads 0 and `halted` reads 0.
- R2: An instruction word holds the opcode in bits [15:12] and the operand address in bits [11:0]. Every non-halting instruction takes exactly three clock cycles, and `pc` then advances by one. A program of N non-halting instructions followed by a halt raises `halted` on the (3N+2)-th rising edge after reset is released.
- R3: Opcode 1 (load) places the addressed data word in the accumulator.
- R4: Opcode 2 (store) writes the accumulator to the addressed word. It pulses `st_we` for one cycle, with `st_addr` equal to the 12-bit operand field and `st_data` equal to the accumulator, and it leaves the accumulator unchanged.
- R5: Opcode 3 replaces the accumulator with accumulator plus operand, and opcode 4 with accumulator minus operand. Both wrap modulo 2^DATA_W.
- R6: Opcode 5 replaces the accumulator with the low DATA_W bits of accumulator times operand.
- R7: Opcode 0 and every opcode from 6 to 15 halt the core. `halted` then stays 1, `pc` keeps the address of the halting instruction, no further store is issued and the accumulator holds its value until reset.
- R8: A data address selects word (address mod DMEM_DEPTH). The bits above the index are ignored.
- R9: If a data-memory preload write (`pl_we`=1, `pl_tgt`=1) and a core store fall in the same cycle, the stored value is written and the preload write is dropped, whatever its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of core state (memories keep contents) |
| pl_we | input | 1 | Preload write strobe |
| pl_tgt | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| pl_addr | input | 12 | Preload word address |
| pl_data | input | DATA_W | Preload data (bits [15:0] for instruction memory) |
| halted | output | 1 | Core has executed a halting opcode |
| pc | output | 12 | Program counter, zero-extended |
| acc_o | output | DATA_W | Accumulator value |
| st_we | output | 1 | Core data-memory write strobe |
| st_addr | output | 12 | Operand field of the active store |
| st_data | output | DATA_W | Value being stored |

## Verification
A core store and a preload write to the data memory can land on the same clock edge, because the preload port stays open while the program runs. The bench watches for the store strobe and raises a preload write on that same cycle. In one run the preload targets the word being stored, and in another run it targets a different word. The program then reloads both words and stores them again. Both reloaded values must show the store's data and the untouched original, which proves that the store won and that the preload was discarded.

// File: rtl/acc_pkg.sv
package acc_pkg;

   localparam int OPC_W   = 4;
   localparam int FLD_W   = 12;
   localparam int INSTR_W = OPC_W + FLD_W;

   localparam logic [OPC_W-1:0] OPC_HALT  = 4'd0;
   localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd1;
   localparam logic [OPC_W-1:0] OPC_STORE = 4'd2;
   localparam logic [OPC_W-1:0] OPC_ADD   = 4'd3;
   localparam logic [OPC_W-1:0] OPC_SUB   = 4'd4;
   localparam logic [OPC_W-1:0] OPC_MUL   = 4'd5;

   typedef enum logic [1:0] {PH_FETCH, PH_EXEC, PH_WB} phase_t;
   typedef enum logic [1:0] {FN_PASS, FN_ADD, FN_SUB, FN_MUL} alu_fn_t;

   function automatic logic opc_stops(input logic [OPC_W-1:0] o);
      return (o == OPC_HALT) || (o > OPC_MUL);
   endfunction

endpackage

// File: rtl/acc_ram.sv
module acc_ram #(
   parameter int WIDTH  = 32,
   parameter int DEPTH  = 64,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WIDTH-1:0]  rdata
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if ((1 << IDX_W) != DEPTH) begin : g_depth_chk
         $error("acc_ram: DEPTH must be a power of two");
      end
      if (IDX_W > ADDR_W) begin : g_addr_chk
         $error("acc_ram: DEPTH exceeds the address range");
      end
      if (WIDTH < 1) begin : g_width_chk
         $error("acc_ram: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] cells [DEPTH];
   logic [IDX_W-1:0] widx, ridx;
   logic             unused_hi;

   assign widx      = waddr[IDX_W-1:0];
   assign ridx      = raddr[IDX_W-1:0];
   assign unused_hi = ^{waddr, raddr};

   always_ff @(posedge clk) begin
      if (we) cells[widx] <= wdata;
      rdata <= cells[ridx];
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MUL_STYLE = 0
) (
   input  alu_fn_t           fn,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] mem_in,
   output logic [DATA_W-1:0] res
);
   logic [DATA_W-1:0] prod;

   generate
      if (MUL_STYLE == 0) begin : g_mul_native
         assign prod = acc_in * mem_in;
      end else if (MUL_STYLE == 1) begin : g_mul_shift
         always_comb begin
            prod = '0;
            for (int i = 0; i < DATA_W; i++) begin
               if (mem_in[i]) prod = prod + (acc_in << i);
            end
         end
      end else begin : g_mul_bad
         $error("acc_alu: MUL_STYLE must be 0 or 1");
         assign prod = '0;
      end
   endgenerate

   always_comb begin
      unique case (fn)
         FN_ADD:  res = acc_in + mem_in;
         FN_SUB:  res = acc_in - mem_in;
         FN_MUL:  res = prod;
         default: res = mem_in;
      endcase
   end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
   import acc_pkg::*;
#(
   parameter int PC_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] ir,
   output logic [PC_W-1:0]    pc_o,
   output logic               halted_o,
   output logic [FLD_W-1:0]   opnd_o,
   output logic               st_we_o,
   output logic               acc_we_o,
   output alu_fn_t            fn_o
);
   phase_t           ph_q;
   logic [PC_W-1:0]  pc_q;
   logic             halt_q;
   logic [OPC_W-1:0] opc;
   logic             stop;

   assign opc      = ir[INSTR_W-1 -: OPC_W];
   assign opnd_o   = ir[FLD_W-1:0];
   assign stop     = opc_stops(opc);
   assign pc_o     = pc_q;
   assign halted_o = halt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_FETCH;
         pc_q   <= '0;
         halt_q <= 1'b0;
      end else if (!halt_q) begin
         unique case (ph_q)
            PH_FETCH: ph_q <= PH_EXEC;
            PH_EXEC: begin
               if (stop) halt_q <= 1'b1;
               else      ph_q   <= PH_WB;
            end
            PH_WB: begin
               pc_q <= pc_q + PC_W'(1);
               ph_q <= PH_FETCH;
            end
            default: ph_q <= PH_FETCH;
         endcase
      end
   end

   always_comb begin
      st_we_o  = (ph_q == PH_EXEC) && (opc == OPC_STORE);
      acc_we_o = 1'b0;
      fn_o     = FN_PASS;
      if (ph_q == PH_WB) begin
         unique case (opc)
            OPC_LOAD: begin acc_we_o = 1'b1; fn_o = FN_PASS; end
            OPC_ADD:  begin acc_we_o = 1'b1; fn_o = FN_ADD;  end
            OPC_SUB:  begin acc_we_o = 1'b1; fn_o = FN_SUB;  end
            OPC_MUL:  begin acc_we_o = 1'b1; fn_o = FN_MUL;  end
            default:  ;
         endcase
      end
   end

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halt_q |=> halt_q); // R7
   AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) halt_q |=> $stable(pc_q)); // R7
   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (ph_q == PH_WB) |=> (pc_q == PC_W'($past(pc_q) + PC_W'(1)))); // R2
   AST_WB_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n) (ph_q == PH_WB) |-> ($past(ph_q) == PH_EXEC)); // R2

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IMEM_DEPTH = 64,
   parameter int DMEM_DEPTH = 64,
   parameter int MUL_STYLE  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pl_we,
   input  logic              pl_tgt,
   input  logic [11:0]       pl_addr,
   input  logic [DATA_W-1:0] pl_data,
   output logic              halted,
   output logic [11:0]       pc,
   output logic [DATA_W-1:0] acc_o,
   output logic              st_we,
   output logic [11:0]       st_addr,
   output logic [DATA_W-1:0] st_data
);
   localparam int PC_W = (IMEM_DEPTH > 1) ? $clog2(IMEM_DEPTH) : 1;

   generate
      if (DATA_W < INSTR_W) begin : g_w_chk
         $error("acc_core: DATA_W must cover an instruction word");
      end
      if (PC_W > FLD_W) begin : g_pc_chk
         $error("acc_core: IMEM_DEPTH exceeds the program counter range");
      end
   endgenerate

   logic [INSTR_W-1:0] ir_q;
   logic [DATA_W-1:0]  mem_q;
   logic [DATA_W-1:0]  acc_q;
   logic [DATA_W-1:0]  alu_res;
   logic [PC_W-1:0]    pc_q;
   logic [FLD_W-1:0]   opnd;
   logic               core_st;
   logic               acc_we;
   alu_fn_t            fn;

   logic               im_we;
   logic               dm_we;
   logic [FLD_W-1:0]   dm_waddr;
   logic [DATA_W-1:0]  dm_wdata;

   acc_ctrl #(.PC_W(PC_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ir       (ir_q),
      .pc_o     (pc_q),
      .halted_o (halted),
      .opnd_o   (opnd),
      .st_we_o  (core_st),
      .acc_we_o (acc_we),
      .fn_o     (fn)
   );

   assign im_we = pl_we && !pl_tgt;

   acc_ram #(.WIDTH(INSTR_W), .DEPTH(IMEM_DEPTH), .ADDR_W(FLD_W)) u_imem (
      .clk   (clk),
      .we    (im_we),
      .waddr (pl_addr),
      .wdata (pl_data[INSTR_W-1:0]),
      .raddr (FLD_W'(pc_q)),
      .rdata (ir_q)
   );

   // a core store owns the single data write port; preload yields
   always_comb begin
      if (core_st) begin
         dm_we    = 1'b1;
         dm_waddr = opnd;
         dm_wdata = acc_q;
      end else begin
         dm_we    = pl_we && pl_tgt;
         dm_waddr = pl_addr;
         dm_wdata = pl_data;
      end
   end

   acc_ram #(.WIDTH(DATA_W), .DEPTH(DMEM_DEPTH), .ADDR_W(FLD_W)) u_dmem (
      .clk   (clk),
      .we    (dm_we),
      .waddr (dm_waddr),
      .wdata (dm_wdata),
      .raddr (opnd),
      .rdata (mem_q)
   );

   acc_alu #(.DATA_W(DATA_W), .MUL_STYLE(MUL_STYLE)) u_alu (
      .fn     (fn),
      .acc_in (acc_q),
      .mem_in (mem_q),
      .res    (alu_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (acc_we) acc_q <= alu_res;
   end

   assign pc      = FLD_W'(pc_q);
   assign acc_o   = acc_q;
   assign st_we   = core_st;
   assign st_addr = opnd;
   assign st_data = acc_q;

   AST_HALT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n) halted |-> !core_st); // R7
   AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n) core_st |=> $stable(acc_q)); // R4
   AST_ACC_WRITE_ONLY_WB: assert property (@(posedge clk) disable iff (!rst_n) (acc_q != $past(acc_q)) |-> $past(acc_we)); // R3

endmodule

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        pl_we, pl_tgt;
   logic [11:0] pl_addr;
   logic [31:0] pl_data;
   logic        halted, st_we;
   logic [11:0] pc, st_addr;
   logic [31:0] acc_o, st_data;

   always #2 clk = ~clk;

   acc_core #(.DATA_W(32), .IMEM_DEPTH(64), .DMEM_DEPTH(64), .MUL_STYLE(0)) u0 (
      .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_tgt(pl_tgt), .pl_addr(pl_addr),
      .pl_data(pl_data), .halted(halted), .pc(pc), .acc_o(acc_o),
      .st_we(st_we), .st_addr(st_addr), .st_data(st_data)
   );

   int          n_run = 0;
   int          n_bad = 0;
   int          nst   = 0;
   int          cyc;
   logic [11:0] sa [16];
   logic [31:0] sd [16];
   logic        inj_on, inj_fired;
   logic [11:0] inj_a;
   logic [31:0] vals [6];

   always @(negedge clk) begin
      if (rst_n && st_we) begin
         if (nst < 16) begin
            sa[nst] = st_addr;
            sd[nst] = st_data;
         end
         nst = nst + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ins(input int op, input int a);
      return {16'h0, 4'(op), 12'(a)};
   endfunction

   task automatic put(input logic tgt, input int a, input logic [31:0] d);
      @(negedge clk);
      pl_we = 1'b1; pl_tgt = tgt; pl_addr = 12'(a); pl_data = d;
      @(posedge clk);
      #1 pl_we = 1'b0;
   endtask

   task automatic hold_reset;
      @(negedge clk);
      rst_n = 1'b0;
      nst   = 0;
   endtask

   task automatic run(output int c);
      @(negedge clk);
      rst_n = 1'b1;
      c = 0;
      while (1) begin
         @(posedge clk);
         c++;
         @(negedge clk);
         if (pl_we) pl_we = 1'b0;
         if (inj_on && !inj_fired && st_we) begin
            pl_we = 1'b1; pl_tgt = 1'b1; pl_addr = inj_a; pl_data = 32'hDEAD_BEEF;
            inj_fired = 1'b1;
         end
         if (halted) break;
         if (c > 2000) begin
            n_run++; n_bad++;
            $display("FAIL R2 no halt actual=%0d expected=halt", c);
            break;
         end
      end
   endtask

   initial begin
      #(4.0 * 200000);
      n_run++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; pl_we = 1'b0; pl_tgt = 1'b0; pl_addr = '0; pl_data = '0;
      inj_on = 1'b0; inj_fired = 1'b0; inj_a = '0;
      vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
      vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_5678;
      repeat (3) @(negedge clk);
      chk("R1 pc in reset", 32'(pc), 0);
      chk("R1 acc in reset", acc_o, 0);
      chk("R1 halted in reset", 32'(halted), 0);

      // main program: load, add, store, sub, store, mul, aliased store, reload
      put(1, 1, 25); put(1, 2, 7); put(1, 3, 64); put(1, 4, 3);
      put(0, 0, ins(1, 1));  put(0, 1, ins(3, 2));  put(0, 2, ins(2, 10));
      put(0, 3, ins(4, 3));  put(0, 4, ins(2, 11)); put(0, 5, ins(5, 4));
      put(0, 6, ins(2, 74)); put(0, 7, ins(1, 10)); put(0, 8, ins(0, 0));
      run(cyc);
      chk("R2 edges to halt", 32'(cyc), 26);
      chk("R7 halted", 32'(halted), 1);
      chk("R7 pc at halt", 32'(pc), 8);
      chk("R8 aliased reload", acc_o, 32'hFFFF_FFA0);
      chk("R4 store count", 32'(nst), 3);
      chk("R4 store0 addr", 32'(sa[0]), 10);
      chk("R5 add result stored", sd[0], 32);
      chk("R4 store1 addr", 32'(sa[1]), 11);
      chk("R5 sub wraps", sd[1], 32'hFFFF_FFE0);
      chk("R8 store field shown", 32'(sa[2]), 74);
      chk("R6 mul low bits", sd[2], 32'hFFFF_FFA0);
      repeat (10) @(negedge clk);
      chk("R7 pc frozen", 32'(pc), 8);
      chk("R7 acc frozen", acc_o, 32'hFFFF_FFA0);
      chk("R7 no later store", 32'(nst), 3);
      hold_reset;
      @(negedge clk);
      chk("R1 pc after reset", 32'(pc), 0);
      chk("R1 acc after reset", acc_o, 0);
      chk("R1 halted after reset", 32'(halted), 0);

      // every halting opcode
      for (int op = 0; op < 16; op++) begin
         if (op == 0 || op > 5) begin
            hold_reset;
            put(1, 1, 25);
            put(0, 0, ins(1, 1)); put(0, 1, ins(op, 2));
            put(0, 2, ins(2, 20)); put(0, 3, ins(0, 0));
            run(cyc);
            chk("R7 halt opcode edges", 32'(cyc), 5);
            chk("R7 halt opcode pc", 32'(pc), 1);
            chk("R7 halt opcode no store", 32'(nst), 0);
            chk("R3 load before halt", acc_o, 25);
         end
      end

      // arithmetic sweep
      for (int a = 0; a < 6; a++) begin
         for (int b = 0; b < 6; b++) begin
            for (int k = 0; k < 3; k++) begin
               logic [31:0] e;
               hold_reset;
               put(1, 0, vals[a]); put(1, 1, vals[b]);
               put(0, 0, ins(1, 0)); put(0, 1, ins(3 + k, 1));
               put(0, 2, ins(2, 2)); put(0, 3, ins(0, 0));
               run(cyc);
               if (k == 0)      e = vals[a] + vals[b];
               else if (k == 1) e = vals[a] - vals[b];
               else             e = vals[a] * vals[b];
               if (k == 2) begin
                  chk("R6 mul stored", sd[0], e);
                  chk("R6 mul acc", acc_o, e);
               end else begin
                  chk("R5 add/sub stored", sd[0], e);
                  chk("R5 add/sub acc", acc_o, e);
               end
               chk("R2 three-instruction edges", 32'(cyc), 11);
            end
         end
      end

      // preload colliding with a store, same word then other word
      for (int s = 0; s < 2; s++) begin
         hold_reset;
         put(1, 0, 32'hA5A5_0001); put(1, 5, 0); put(1, 7, 32'h77);
         put(0, 0, ins(1, 0)); put(0, 1, ins(2, 5)); put(0, 2, ins(1, 5));
         put(0, 3, ins(2, 6)); put(0, 4, ins(1, 7)); put(0, 5, ins(2, 8));
         put(0, 6, ins(0, 0));
         inj_on = 1'b1; inj_fired = 1'b0; inj_a = (s == 0) ? 12'd5 : 12'd7;
         run(cyc);
         inj_on = 1'b0;
         chk("R9 store count", 32'(nst), 3);
         chk("R9 contested word keeps store", sd[1], 32'hA5A5_0001);
         chk("R9 other word untouched", sd[2], 32'h77);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

endmodule